// File: doc/BRIEF.md
# Gated-Stage Time-of-Day Counter

This block keeps the time of day as three cascaded stages: seconds, minutes and hours. A once-per-second pulse clocks the seconds stage. Each later stage is clocked by a carry clock. That carry clock is the earlier stage's terminal-count flag ANDed with the earlier stage's own clock level. The minutes stage therefore ticks only during the high phase of the pulse that follows the seconds reaching 59. The hours stage ticks only when the minutes are also at 59.

Each stage's next-state logic sits behind an isolation gate. That gate is enabled by the stage's clock level as sampled. While the level is low, the next-state value reads as all zeros. The count registers are never gated, so they keep their value through the idle interval. They change only on a falling edge of their stage clock.

All registers run on one fast system clock. The seconds pulse is sampled on that clock. A falling edge is a sample that is high followed by a sample that is low. The carry clocks are combinational outputs formed from the live pulse and the registered counts.

Top module: `todClockTop`

## Requirements
- R1: On each system clock edge where the sampled seconds pulse is low and the previous sample was high, `seconds` advances by one, and 59 is followed by 0.
- R2: `seconds` and `minutes` never leave the range 0..59. `hours` never leaves 0..23.
- R3: `minutes` changes only on the edge where `seconds` goes from 59 to 0, and it changes in that same edge. It advances by one, and 59 is followed by 0.
- R4: `hours` changes only on the edge where `minutes` goes from 59 to 0, and it changes in that same edge. It advances by one, and 23 is followed by 0.
- R5: `minCarryClk` is 1 exactly when `seconds` equals 59 and `secPulse` is high. At all other times it is 0.
- R6: `hourCarryClk` is 1 exactly when `minutes` equals 59 and `minCarryClk` is 1. At all other times it is 0.
- R7: A rising edge of `secPulse`, and the length of its high or low phase, do not change any count. Counts hold on every edge that is not a sampled falling edge.
- R8: After 86399 falling edges from reset, the time reads 23:59:59. The next falling edge makes it 00:00:00.
- R9: While `rst` is high, independent of `sysClk`, all three counts are 0. With `secPulse` low, both carry clocks are also 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock that samples the pulse and updates all registers |
| rst | input | 1 | Asynchronous active-high reset |
| secPulse | input | 1 | Once-per-second pulse; its falling edge advances the seconds |
| seconds | output | 6 | Seconds count, 0..59 |
| minutes | output | 6 | Minutes count, 0..59 |
| hours | output | 5 | Hours count, 0..23 |
| minCarryClk | output | 1 | Gated carry clock from the seconds stage to the minutes stage |
| hourCarryClk | output | 1 | Gated carry clock from the minutes stage to the hours stage |

## Verification
The properties assume that `secPulse` is synchronous to `sysClk` and stable around each rising edge. Each of its levels is assumed to last at least one system clock, so that each falling edge is seen as exactly one high-then-low sample pair. The stimulus changes the pulse only on the falling edge of `sysClk`. The stimulus holds every phase for one cycle or more, using several different high and low widths. The stimulus raises the reset asynchronously between edges and holds it across at least two rising edges before releasing it.

// File: rtl/todPkg.sv
`timescale 1ns/1ps
package todPkg;
  localparam int NSTAGE = 3;

  typedef struct packed {
    logic [NSTAGE-1:0] fall;   // sampled falling edge of each stage clock
    logic [NSTAGE-1:0] enLvl;  // sampled level of each stage clock (isolation enable)
  } todStrobe_t;
endpackage

// File: rtl/isoGate.sv
`timescale 1ns/1ps
// Isolation AND: output forced to zero while enable is low.
module isoGate #(
  parameter int W = 1
) (
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  assign dout = din & {W{en}};
endmodule

// File: rtl/todStage.sv
`timescale 1ns/1ps
// One modulo counter stage with isolated next-state logic and ungated state.
module todStage #(
  parameter int MOD = 60,
  parameter int W   = $clog2(MOD)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         enLvl,
  input  logic         fall,
  output logic [W-1:0] count
);
  logic [W-1:0] nextRaw;
  logic [W-1:0] nextIso;

  assign nextRaw = (count == W'(MOD - 1)) ? '0 : count + 1'b1;

  isoGate #(.W(W)) u_iso (
    .en  (enLvl),
    .din (nextRaw),
    .dout(nextIso)
  );

  always_ff @(posedge clk or posedge rst) begin
    if (rst)       count <= '0;
    else if (fall) count <= nextIso;
  end
endmodule

// File: rtl/todCarryCtl.sv
`timescale 1ns/1ps
// Builds gated stage clocks and sampled edge/level strobes.
module todCarryCtl
  import todPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              secPulse,
  input  logic [NSTAGE-2:0] termFlag,
  output todStrobe_t        stb,
  output logic [NSTAGE-2:0] carryClk
);
  logic [NSTAGE-1:0] stageClk;
  logic [NSTAGE-1:0] prevClk;

  assign stageClk[0] = secPulse;

  for (genvar g = 1; g < NSTAGE; g++) begin : g_carry
    isoGate #(.W(1)) u_iso (
      .en  (stageClk[g-1]),
      .din (termFlag[g-1]),
      .dout(stageClk[g])
    );
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) prevClk <= '0;
    else     prevClk <= stageClk;
  end

  assign stb.fall  = prevClk & ~stageClk;
  assign stb.enLvl = prevClk;
  assign carryClk  = stageClk[NSTAGE-1:1];
endmodule

// File: rtl/todCountPath.sv
`timescale 1ns/1ps
// Datapath: the three counter stages and their terminal-count decode.
module todCountPath
  import todPkg::*;
#(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24,
  parameter int TOTW    = $clog2(SEC_MOD) + $clog2(MIN_MOD) + $clog2(HR_MOD)
) (
  input  logic              clk,
  input  logic              rst,
  input  todStrobe_t        stb,
  output logic [TOTW-1:0]   cntFlat,
  output logic [NSTAGE-2:0] termFlag
);
  localparam int SW = $clog2(SEC_MOD);
  localparam int MW = $clog2(MIN_MOD);
  localparam int HW = $clog2(HR_MOD);
  localparam int MODV [NSTAGE] = '{SEC_MOD, MIN_MOD, HR_MOD};
  localparam int WV   [NSTAGE] = '{SW, MW, HW};
  localparam int OFFV [NSTAGE] = '{0, SW, SW + MW};

  for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
    localparam int M = MODV[g];
    localparam int W = WV[g];
    localparam int O = OFFV[g];
    logic [W-1:0] cnt;

    todStage #(.MOD(M), .W(W)) u_stage (
      .clk  (clk),
      .rst  (rst),
      .enLvl(stb.enLvl[g]),
      .fall (stb.fall[g]),
      .count(cnt)
    );

    assign cntFlat[O +: W] = cnt;

    if (g < NSTAGE - 1) begin : g_term
      assign termFlag[g] = (cnt == W'(M - 1));
    end
  end
endmodule

// File: rtl/todClockTop.sv
`timescale 1ns/1ps
module todClockTop
  import todPkg::*;
#(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24
) (
  input  logic                       sysClk,
  input  logic                       rst,
  input  logic                       secPulse,
  output logic [$clog2(SEC_MOD)-1:0] seconds,
  output logic [$clog2(MIN_MOD)-1:0] minutes,
  output logic [$clog2(HR_MOD)-1:0]  hours,
  output logic                       minCarryClk,
  output logic                       hourCarryClk
);
  localparam int SW   = $clog2(SEC_MOD);
  localparam int MW   = $clog2(MIN_MOD);
  localparam int HW   = $clog2(HR_MOD);
  localparam int TOTW = SW + MW + HW;

  todStrobe_t        stb;
  logic [TOTW-1:0]   cntFlat;
  logic [NSTAGE-2:0] termFlag;
  logic [NSTAGE-2:0] carryClk;

  todCarryCtl u_ctl (
    .clk     (sysClk),
    .rst     (rst),
    .secPulse(secPulse),
    .termFlag(termFlag),
    .stb     (stb),
    .carryClk(carryClk)
  );

  todCountPath #(
    .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD), .TOTW(TOTW)
  ) u_path (
    .clk     (sysClk),
    .rst     (rst),
    .stb     (stb),
    .cntFlat (cntFlat),
    .termFlag(termFlag)
  );

  assign seconds      = cntFlat[SW-1:0];
  assign minutes      = cntFlat[SW +: MW];
  assign hours        = cntFlat[SW+MW +: HW];
  assign minCarryClk  = carryClk[0];
  assign hourCarryClk = carryClk[1];
endmodule

// File: rtl/todClockChecker.sv
`timescale 1ns/1ps
module todClockChecker #(
  parameter int SEC_MOD = 60,
  parameter int MIN_MOD = 60,
  parameter int HR_MOD  = 24
) (
  input logic                       sysClk,
  input logic                       rst,
  input logic                       secPulse,
  input logic [$clog2(SEC_MOD)-1:0] seconds,
  input logic [$clog2(MIN_MOD)-1:0] minutes,
  input logic [$clog2(HR_MOD)-1:0]  hours,
  input logic                       minCarryClk,
  input logic                       hourCarryClk
);
  localparam int SW = $clog2(SEC_MOD);

  logic chkPrev;
  logic fallNow;

  always_ff @(posedge sysClk or posedge rst) begin
    if (rst) chkPrev <= 1'b0;
    else     chkPrev <= secPulse;
  end
  assign fallNow = chkPrev && !secPulse;

  p_sec_step_r1: assert property (@(posedge sysClk) disable iff (rst)
    fallNow |=> seconds == (($past(seconds) == SW'(SEC_MOD-1)) ? '0 : SW'($past(seconds) + 1'b1)));

  p_range_r2: assert property (@(posedge sysClk) disable iff (rst)
    (int'(seconds) < SEC_MOD) && (int'(minutes) < MIN_MOD) && (int'(hours) < HR_MOD));

  p_min_follow_r3: assert property (@(posedge sysClk) disable iff (rst)
    !$stable(minutes) |-> ($past(int'(seconds)) == SEC_MOD-1) && (seconds == '0));

  p_hr_follow_r4: assert property (@(posedge sysClk) disable iff (rst)
    !$stable(hours) |-> ($past(int'(minutes)) == MIN_MOD-1) && (minutes == '0));

  p_min_clk_r5: assert property (@(posedge sysClk) disable iff (rst)
    minCarryClk |-> secPulse && (int'(seconds) == SEC_MOD-1));

  p_min_clk_on_r5: assert property (@(posedge sysClk) disable iff (rst)
    (secPulse && (int'(seconds) == SEC_MOD-1)) |-> minCarryClk);

  p_hr_clk_r6: assert property (@(posedge sysClk) disable iff (rst)
    hourCarryClk |-> minCarryClk && (int'(minutes) == MIN_MOD-1));

  p_hold_r7: assert property (@(posedge sysClk) disable iff (rst)
    !fallNow |=> $stable(seconds));
endmodule

bind todClockTop todClockChecker #(
  .SEC_MOD(SEC_MOD), .MIN_MOD(MIN_MOD), .HR_MOD(HR_MOD)
) u_chk (
  .sysClk      (sysClk),
  .rst         (rst),
  .secPulse    (secPulse),
  .seconds     (seconds),
  .minutes     (minutes),
  .hours       (hours),
  .minCarryClk (minCarryClk),
  .hourCarryClk(hourCarryClk)
);

// File: tb/todClockTop_bench.sv
`timescale 1ns/1ps
module todClockTop_bench;
  logic       sysClk = 1'b0;
  logic       rst = 1'b1;
  logic       secPulse = 1'b0;
  logic [5:0] seconds;
  logic [5:0] minutes;
  logic [4:0] hours;
  logic       minCarryClk;
  logic       hourCarryClk;

  int nCompared = 0;
  int nMismatched = 0;
  bit done = 0;

  int refSec = 0, refMin = 0, refHr = 0;
  bit refPrev = 0;

  always #2.5 sysClk = ~sysClk;

  todClockTop u_todClockTop (
    .sysClk(sysClk), .rst(rst), .secPulse(secPulse),
    .seconds(seconds), .minutes(minutes), .hours(hours),
    .minCarryClk(minCarryClk), .hourCarryClk(hourCarryClk)
  );

  // Behavioural reference: time of day as integers.
  always @(posedge sysClk or posedge rst) begin
    if (rst) begin
      refSec = 0; refMin = 0; refHr = 0; refPrev = 0;
    end else begin
      if (refPrev && !secPulse) begin
        refSec++;
        if (refSec == 60) begin
          refSec = 0; refMin++;
          if (refMin == 60) begin
            refMin = 0; refHr++;
            if (refHr == 24) refHr = 0;
          end
        end
      end
      refPrev = secPulse;
    end
  end

  task automatic check(string tag, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nMismatched++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic checkAll();
    bit expMin, expHr;
    expMin = (refSec == 59) && secPulse;
    expHr  = expMin && (refMin == 59);
    check("R1/R7 seconds", int'(seconds), refSec);
    check("R3 minutes", int'(minutes), refMin);
    check("R4 hours", int'(hours), refHr);
    check("R5 minCarryClk", int'(minCarryClk), int'(expMin));
    check("R6 hourCarryClk", int'(hourCarryClk), int'(expHr));
    check("R2 range", int'(seconds < 60 && minutes < 60 && hours < 24), 1);
  endtask

  task automatic drive(bit v, int n);
    for (int i = 0; i < n; i++) begin
      @(negedge sysClk);
      checkAll();
      secPulse = v;
    end
  endtask

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  endtask

  initial begin
    repeat (199000) @(posedge sysClk);
    if (!done) begin
      nCompared++;
      nMismatched++;
      $display("FAIL watchdog expired at %0t", $time);
      finishRun();
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge sysClk);
    check("R9 reset seconds", int'(seconds), 0);
    check("R9 reset minutes", int'(minutes), 0);
    check("R9 reset hours", int'(hours), 0);
    check("R9 reset minCarryClk", int'(minCarryClk), 0);
    check("R9 reset hourCarryClk", int'(hourCarryClk), 0);
    rst = 1'b0;

    // Varied pulse widths through a minute carry (R1, R3, R5, R7)
    for (int p = 0; p < 62; p++) begin
      drive(1'b1, 1 + (p % 3));
      drive(1'b0, 1 + ((p * 7) % 4));
    end
    @(negedge sysClk);
    checkAll();
    check("R3 minute after 62 pulses", int'(minutes), 1);
    check("R1 seconds after 62 pulses", int'(seconds), 2);

    // Long high phase: no advance on the rising edge (R7)
    drive(1'b1, 6);
    @(negedge sysClk);
    checkAll();
    check("R7 hold during high", int'(seconds), 2);

    // Asynchronous reset in mid-cycle (R9)
    secPulse = 1'b0;
    #1 rst = 1'b1;
    #1;
    check("R9 async seconds", int'(seconds), 0);
    check("R9 async minutes", int'(minutes), 0);
    check("R9 async hours", int'(hours), 0);
    check("R9 async minCarryClk", int'(minCarryClk), 0);
    repeat (2) @(posedge sysClk);
    @(negedge sysClk);
    rst = 1'b0;

    // Full day with one-cycle phases (R8, R4, R6)
    for (int p = 0; p < 86399; p++) begin
      drive(1'b1, 1);
      drive(1'b0, 1);
    end
    @(negedge sysClk);
    checkAll();
    check("R8 end of day hours", int'(hours), 23);
    check("R8 end of day minutes", int'(minutes), 59);
    check("R8 end of day seconds", int'(seconds), 59);
    secPulse = 1'b1;
    @(negedge sysClk);
    checkAll();
    check("R6 hour carry high", int'(hourCarryClk), 1);
    secPulse = 1'b0;
    @(negedge sysClk);
    checkAll();
    check("R8 wrap hours", int'(hours), 0);
    check("R8 wrap minutes", int'(minutes), 0);
    check("R8 wrap seconds", int'(seconds), 0);
    check("R6 hour carry low after wrap", int'(hourCarryClk), 0);

    done = 1;
    finishRun();
  end
endmodule